// File: doc/BRIEF.md
# Per-Thread Memory Request Staging Queues

This block is the entry stage of a multithreaded load/store pipeline. Memory instructions arrive with their fetched operands and a thread number. Each one is written into a small FIFO that belongs to that thread. Before the write, the store data is reshaped by access size. The oldest entry of every thread's FIFO is shown to the next stage at the same time. In the same cycle, the next stage answers with a per-thread consume mask, and a set bit pops that thread's FIFO at the clock edge.

A single recycle slot takes back a request that missed further down the pipe. It holds the request and offers it again on its own output. While that slot holds a request for a thread, that thread's normal head is withheld, so the recycled request takes priority over new traffic.

Top module: `mem_req_stager`

## Requirements
- R1: After reset, every queue is empty and not full, every headValid bit is 0, and recycleValid is 0.
- R2: When instValid or instFlush is high and the queue selected by instThread is not full, one entry holding tag, address, size, vector flag, flush flag and reshaped data is appended to that queue only. Each queue returns its entries in arrival order.
- R3: A queue reports full when it holds DEPTH entries. While it is full, an enqueue to it is refused and its contents stay unchanged, even if the same thread is popped in that cycle.
- R4: The head fields of all threads are driven in parallel. headValid[i] is high exactly when queue i is not empty and the recycle slot does not hold a request for thread i. queueEmpty[i] is high exactly when queue i holds no entry.
- R5: When consumeMask[i] is high while headValid[i] is high, queue i is popped at that clock edge. When the bit is low, or headValid[i] is low, queue i's head entry stays in place.
- R6: Scalar data (instIsVec=0) keeps only word lane 0 and clears the other lanes. With size 0 (byte), bits 7:0 are copied into all four bytes of lane 0. With size 1 (half), bits 15:0 are copied into both halves of lane 0. With size 2 or 3 (word), bits 31:0 are kept as they are.
- R7: Vector data (instIsVec=1) is packed toward bit 0. With size 0, byte k of the result is bits [32k+7:32k] of the input. With size 1, half-word k of the result is bits [32k+15:32k] of the input. All higher result bits are zero. With size 2 or 3, the data is kept unchanged.
- R8: When instFlush is high, an entry is enqueued even if instValid is low, and that entry's headFlush bit reads 1.
- R9: When missValid is high, the recycle slot captures missThread, missTag, missAddr, missData, missSize and missVec unchanged, and recycleValid is high from the next cycle.
- R10: While recycleValid is high, headValid is low for the thread held in the slot, and a consume bit for that thread leaves its queue unchanged.
- R11: recycleConsume empties the slot at the clock edge. If missValid is high in the same cycle, the new capture takes effect and recycleValid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Incoming memory instruction valid |
| instFlush | input | 1 | Flush request; forces an enqueue |
| instThread | input | TW | Thread of the incoming instruction |
| instTag | input | TAG_W | Instruction tag/opcode bits |
| instAddr | input | ADDR_W | Effective address operand |
| instData | input | LANES*32 | Store data operand, one 32-bit slot per lane |
| instSize | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| instIsVec | input | 1 | Vector access flag |
| consumeMask | input | THREADS | Per-thread pop request from downstream |
| missValid | input | 1 | Missed request returned for recycling |
| missThread | input | TW | Thread of the missed request |
| missTag | input | TAG_W | Tag of the missed request |
| missAddr | input | ADDR_W | Address of the missed request |
| missData | input | LANES*32 | Data of the missed request |
| missSize | input | 2 | Size of the missed request |
| missVec | input | 1 | Vector flag of the missed request |
| recycleConsume | input | 1 | Downstream took the recycled request |
| queueFull | output | THREADS | Per-thread full flag |
| queueEmpty | output | THREADS | Per-thread empty flag |
| headValid | output | THREADS | Per-thread head offered |
| headTag | output | THREADS*TAG_W | Head tags, thread i at [i*TAG_W +: TAG_W] |
| headAddr | output | THREADS*ADDR_W | Head addresses |
| headData | output | THREADS*LANES*32 | Head reshaped data |
| headSize | output | THREADS*2 | Head access sizes |
| headVec | output | THREADS | Head vector flags |
| headFlush | output | THREADS | Head flush flags |
| recycleValid | output | 1 | Recycle slot occupied |
| recycleThread | output | TW | Thread held in recycle slot |
| recycleTag | output | TAG_W | Recycled tag |
| recycleAddr | output | ADDR_W | Recycled address |
| recycleData | output | LANES*32 | Recycled data |
| recycleSize | output | 2 | Recycled size |
| recycleVec | output | 1 | Recycled vector flag |

## Verification
The assertions assume that the downstream stage never returns a miss while the recycle slot is occupied, unless it also asserts recycleConsume in that same cycle. A capture in any other case would overwrite a pending request. The stimulus generator therefore raises missValid only when its own model shows the slot empty, or when it drives recycleConsume at the same time. Consume bits and enqueues are left free, including consume bits for threads with no valid head and enqueues into full queues. These are the cases where the block must ignore or refuse the input. Access sizes are drawn only from 0 to 2.

// File: rtl/mem_req_stager_pkg.sv
package mem_req_stager_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic enqEn;    // write the incoming request at wrIdx of instThread
    logic rcyLoad;  // capture the missed request into the recycle slot
  } stagerStrobes_t;

endpackage

// File: rtl/mem_req_stager_ctrl.sv
module mem_req_stager_ctrl
  import mem_req_stager_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic                  instFlush,
  input  logic [TW-1:0]         instThread,
  input  logic [THREADS-1:0]    consumeMask,
  input  logic                  missValid,
  input  logic [TW-1:0]         missThread,
  input  logic                  recycleConsume,
  output stagerStrobes_t        strb,
  output logic [PW-1:0]         wrIdx,
  output logic [THREADS*PW-1:0] rdPtrFlat,
  output logic [THREADS-1:0]    fullV,
  output logic [THREADS-1:0]    emptyV,
  output logic [THREADS-1:0]    headValidV,
  output logic                  rcyValid,
  output logic [TW-1:0]         rcyThread
);

  logic [CW-1:0] cnt [THREADS];
  logic [PW-1:0] wp  [THREADS];
  logic [PW-1:0] rp  [THREADS];
  logic [THREADS-1:0] pushV, popV;
  logic enqReq, enqOk;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign enqReq = instValid | instFlush;
  assign enqOk  = enqReq && !fullV[instThread];

  always_comb begin
    for (int i = 0; i < THREADS; i++) begin
      fullV[i]       = (cnt[i] == CW'(DEPTH));
      emptyV[i]      = (cnt[i] == '0);
      headValidV[i]  = !emptyV[i] && !(rcyValid && rcyThread == TW'(i));
      popV[i]        = consumeMask[i] && headValidV[i];
      pushV[i]       = enqOk && (instThread == TW'(i));
      rdPtrFlat[i*PW +: PW] = rp[i];
    end
  end

  assign wrIdx        = wp[instThread];
  assign strb.enqEn   = enqOk;
  assign strb.rcyLoad = missValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < THREADS; i++) begin
        cnt[i] <= '0;
        wp[i]  <= '0;
        rp[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < THREADS; i++) begin
        if (pushV[i]) wp[i] <= bump(wp[i]);
        if (popV[i])  rp[i] <= bump(rp[i]);
        if (pushV[i] && !popV[i])      cnt[i] <= cnt[i] + 1'b1;
        else if (!pushV[i] && popV[i]) cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end

  // Recycle slot occupancy; a new capture wins over a consume
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcyValid  <= 1'b0;
      rcyThread <= '0;
    end else if (missValid) begin
      rcyValid  <= 1'b1;
      rcyThread <= missThread;
    end else if (recycleConsume) begin
      rcyValid  <= 1'b0;
    end
  end

  for (genvar g = 0; g < THREADS; g++) begin : gChk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= CW'(DEPTH));
    p_refuse_full_r3: assert property (@(posedge clk) disable iff (!rstN)
      (enqReq && instThread == TW'(g) && fullV[g] && !consumeMask[g]) |=> $stable(cnt[g]) && $stable(wp[g]));
    p_head_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !consumeMask[g] |=> $stable(rp[g]));
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({fullV[g], emptyV[g]}));
  end

  p_recycle_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> (!rcyValid || recycleConsume));
  p_recycle_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> rcyValid);
  p_recycle_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (recycleConsume && !missValid) |=> !rcyValid);

endmodule

// File: rtl/mem_req_stager_dp.sv
module mem_req_stager_dp
  import mem_req_stager_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int LANES   = 4,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = LANES * 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stagerStrobes_t            strb,
  input  logic [PW-1:0]             wrIdx,
  input  logic [THREADS*PW-1:0]     rdPtrFlat,
  input  logic [TW-1:0]             instThread,
  input  logic [TAG_W-1:0]          instTag,
  input  logic [ADDR_W-1:0]         instAddr,
  input  logic [DW-1:0]             instData,
  input  logic [1:0]                instSize,
  input  logic                      instIsVec,
  input  logic                      instFlush,
  input  logic [TAG_W-1:0]          missTag,
  input  logic [ADDR_W-1:0]         missAddr,
  input  logic [DW-1:0]             missData,
  input  logic [1:0]                missSize,
  input  logic                      missVec,
  output logic [THREADS*TAG_W-1:0]  headTag,
  output logic [THREADS*ADDR_W-1:0] headAddr,
  output logic [THREADS*DW-1:0]     headData,
  output logic [THREADS*2-1:0]      headSize,
  output logic [THREADS-1:0]        headVec,
  output logic [THREADS-1:0]        headFlush,
  output logic [TAG_W-1:0]          recTag,
  output logic [ADDR_W-1:0]         recAddr,
  output logic [DW-1:0]             recData,
  output logic [1:0]                recSize,
  output logic                      recVec
);

  logic [DW-1:0]     shaped;
  logic [TAG_W-1:0]  memTag   [THREADS][DEPTH];
  logic [ADDR_W-1:0] memAddr  [THREADS][DEPTH];
  logic [DW-1:0]     memData  [THREADS][DEPTH];
  logic [1:0]        memSize  [THREADS][DEPTH];
  logic              memVec   [THREADS][DEPTH];
  logic              memFlush [THREADS][DEPTH];

  // Size-dependent reshaping of the store operand
  always_comb begin
    shaped = '0;
    if (instIsVec) begin
      unique case (accSize_e'(instSize))
        SZ_BYTE: for (int k = 0; k < LANES; k++) shaped[8*k +: 8]   = instData[32*k +: 8];
        SZ_HALF: for (int k = 0; k < LANES; k++) shaped[16*k +: 16] = instData[32*k +: 16];
        default: shaped = instData;
      endcase
    end else begin
      unique case (accSize_e'(instSize))
        SZ_BYTE: shaped[31:0] = {4{instData[7:0]}};
        SZ_HALF: shaped[31:0] = {2{instData[15:0]}};
        default: shaped[31:0] = instData[31:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.enqEn) begin
      memTag[instThread][wrIdx]   <= instTag;
      memAddr[instThread][wrIdx]  <= instAddr;
      memData[instThread][wrIdx]  <= shaped;
      memSize[instThread][wrIdx]  <= instSize;
      memVec[instThread][wrIdx]   <= instIsVec;
      memFlush[instThread][wrIdx] <= instFlush;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rcyLoad) begin
      recTag  <= missTag;
      recAddr <= missAddr;
      recData <= missData;
      recSize <= missSize;
      recVec  <= missVec;
    end
  end

  for (genvar g = 0; g < THREADS; g++) begin : gHead
    logic [PW-1:0] rp;
    assign rp = rdPtrFlat[g*PW +: PW];
    assign headTag[g*TAG_W +: TAG_W]    = memTag[g][rp];
    assign headAddr[g*ADDR_W +: ADDR_W] = memAddr[g][rp];
    assign headData[g*DW +: DW]         = memData[g][rp];
    assign headSize[g*2 +: 2]           = memSize[g][rp];
    assign headVec[g]                   = memVec[g][rp];
    assign headFlush[g]                 = memFlush[g][rp];
  end

  p_recycle_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.rcyLoad |=> (recAddr == $past(missAddr)) && (recTag == $past(missTag))
                     && (recData == $past(missData)));

endmodule

// File: rtl/mem_req_stager.sv
module mem_req_stager
  import mem_req_stager_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 4,
  parameter int LANES   = 4,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int DW = LANES * 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instValid,
  input  logic                      instFlush,
  input  logic [TW-1:0]             instThread,
  input  logic [TAG_W-1:0]          instTag,
  input  logic [ADDR_W-1:0]         instAddr,
  input  logic [DW-1:0]             instData,
  input  logic [1:0]                instSize,
  input  logic                      instIsVec,
  input  logic [THREADS-1:0]        consumeMask,
  input  logic                      missValid,
  input  logic [TW-1:0]             missThread,
  input  logic [TAG_W-1:0]          missTag,
  input  logic [ADDR_W-1:0]         missAddr,
  input  logic [DW-1:0]             missData,
  input  logic [1:0]                missSize,
  input  logic                      missVec,
  input  logic                      recycleConsume,
  output logic [THREADS-1:0]        queueFull,
  output logic [THREADS-1:0]        queueEmpty,
  output logic [THREADS-1:0]        headValid,
  output logic [THREADS*TAG_W-1:0]  headTag,
  output logic [THREADS*ADDR_W-1:0] headAddr,
  output logic [THREADS*DW-1:0]     headData,
  output logic [THREADS*2-1:0]      headSize,
  output logic [THREADS-1:0]        headVec,
  output logic [THREADS-1:0]        headFlush,
  output logic                      recycleValid,
  output logic [TW-1:0]             recycleThread,
  output logic [TAG_W-1:0]          recycleTag,
  output logic [ADDR_W-1:0]         recycleAddr,
  output logic [DW-1:0]             recycleData,
  output logic [1:0]                recycleSize,
  output logic                      recycleVec
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stagerStrobes_t        strb;
  logic [PW-1:0]         wrIdx;
  logic [THREADS*PW-1:0] rdPtrFlat;

  mem_req_stager_ctrl #(.THREADS(THREADS), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .instFlush(instFlush), .instThread(instThread),
    .consumeMask(consumeMask),
    .missValid(missValid), .missThread(missThread), .recycleConsume(recycleConsume),
    .strb(strb), .wrIdx(wrIdx), .rdPtrFlat(rdPtrFlat),
    .fullV(queueFull), .emptyV(queueEmpty), .headValidV(headValid),
    .rcyValid(recycleValid), .rcyThread(recycleThread)
  );

  mem_req_stager_dp #(.THREADS(THREADS), .DEPTH(DEPTH), .LANES(LANES),
                      .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdPtrFlat(rdPtrFlat),
    .instThread(instThread), .instTag(instTag), .instAddr(instAddr),
    .instData(instData), .instSize(instSize), .instIsVec(instIsVec),
    .instFlush(instFlush),
    .missTag(missTag), .missAddr(missAddr), .missData(missData),
    .missSize(missSize), .missVec(missVec),
    .headTag(headTag), .headAddr(headAddr), .headData(headData),
    .headSize(headSize), .headVec(headVec), .headFlush(headFlush),
    .recTag(recycleTag), .recAddr(recycleAddr), .recData(recycleData),
    .recSize(recycleSize), .recVec(recycleVec)
  );

endmodule

// File: tb/mem_req_stager_bench.sv
`timescale 1ns/1ps
module mem_req_stager_bench;

  localparam int T = 4, D = 4, DW = 128;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic instValid, instFlush, instIsVec, missValid, missVec, recycleConsume;
  logic [1:0] instThread, missThread, instSize, missSize;
  logic [7:0] instTag, missTag;
  logic [31:0] instAddr, missAddr;
  logic [DW-1:0] instData, missData;
  logic [T-1:0] consumeMask;
  logic [T-1:0] queueFull, queueEmpty, headValid, headVec, headFlush;
  logic [T*8-1:0] headTag;
  logic [T*32-1:0] headAddr;
  logic [T*DW-1:0] headData;
  logic [T*2-1:0] headSize;
  logic recycleValid, recycleVec;
  logic [1:0] recycleThread, recycleSize;
  logic [7:0] recycleTag;
  logic [31:0] recycleAddr;
  logic [DW-1:0] recycleData;

  mem_req_stager u_mem_req_stager (.*);

  // Reference model
  logic [7:0]    mTag [T][D];
  logic [31:0]   mAddr[T][D];
  logic [DW-1:0] mData[T][D];
  logic [1:0]    mSize[T][D];
  logic          mVec [T][D];
  logic          mFl  [T][D];
  int            mCnt [T];
  logic rV, rVec;
  logic [1:0] rThr, rSize;
  logic [7:0] rTag;
  logic [31:0] rAddr;
  logic [DW-1:0] rData;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] expShape(logic v, logic [1:0] s, logic [DW-1:0] d);
    logic [DW-1:0] r = '0;
    if (v) begin
      if (s == 2'd0)      for (int k = 0; k < 4; k++) r[8*k +: 8] = d[32*k +: 8];
      else if (s == 2'd1) for (int k = 0; k < 4; k++) r[16*k +: 16] = d[32*k +: 16];
      else r = d;
    end else begin
      if (s == 2'd0)      r[31:0] = {d[7:0], d[7:0], d[7:0], d[7:0]};
      else if (s == 2'd1) r[31:0] = {d[15:0], d[15:0]};
      else                r[31:0] = d[31:0];
    end
    return r;
  endfunction

  function automatic logic expHv(int i);
    return (mCnt[i] > 0) && !(rV && rThr == 2'(i));
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [T-1:0] hv;
    logic fullPre;
    for (int i = 0; i < T; i++) hv[i] = expHv(i);
    fullPre = (mCnt[instThread] == D);
    for (int i = 0; i < T; i++) begin
      if (consumeMask[i] && hv[i]) begin
        for (int j = 0; j < D - 1; j++) begin
          mTag[i][j] = mTag[i][j+1]; mAddr[i][j] = mAddr[i][j+1];
          mData[i][j] = mData[i][j+1]; mSize[i][j] = mSize[i][j+1];
          mVec[i][j] = mVec[i][j+1]; mFl[i][j] = mFl[i][j+1];
        end
        mCnt[i]--;
      end
    end
    if ((instValid || instFlush) && !fullPre) begin
      int t = int'(instThread);
      int p = mCnt[t];
      mTag[t][p] = instTag; mAddr[t][p] = instAddr;
      mData[t][p] = expShape(instIsVec, instSize, instData);
      mSize[t][p] = instSize; mVec[t][p] = instIsVec; mFl[t][p] = instFlush;
      mCnt[t]++;
    end
    if (missValid) begin
      rV = 1'b1; rThr = missThread; rTag = missTag; rAddr = missAddr;
      rData = missData; rSize = missSize; rVec = missVec;
    end else if (recycleConsume) rV = 1'b0;
  endtask

  task automatic checkAll();
    for (int i = 0; i < T; i++) begin
      chk("R3", "queueFull", DW'(queueFull[i]), DW'(mCnt[i] == D));
      chk("R4", "queueEmpty", DW'(queueEmpty[i]), DW'(mCnt[i] == 0));
      if (rV && rThr == 2'(i)) chk("R10", "headValid", DW'(headValid[i]), DW'(expHv(i)));
      else                     chk("R4", "headValid", DW'(headValid[i]), DW'(expHv(i)));
      if (mCnt[i] > 0) begin
        chk("R5", "headTag", DW'(headTag[i*8 +: 8]), DW'(mTag[i][0]));
        chk("R2", "headAddr", DW'(headAddr[i*32 +: 32]), DW'(mAddr[i][0]));
        chk("R2", "headSize", DW'(headSize[i*2 +: 2]), DW'(mSize[i][0]));
        chk("R8", "headFlush", DW'(headFlush[i]), DW'(mFl[i][0]));
        if (mVec[i][0]) chk("R7", "headData", headData[i*DW +: DW], mData[i][0]);
        else            chk("R6", "headData", headData[i*DW +: DW], mData[i][0]);
      end
    end
    chk("R11", "recycleValid", DW'(recycleValid), DW'(rV));
    if (rV) begin
      chk("R9", "recycleThread", DW'(recycleThread), DW'(rThr));
      chk("R9", "recycleTag", DW'(recycleTag), DW'(rTag));
      chk("R9", "recycleAddr", DW'(recycleAddr), DW'(rAddr));
      chk("R9", "recycleData", recycleData, rData);
      chk("R9", "recycleSize", DW'(recycleSize), DW'(rSize));
      chk("R9", "recycleVec", DW'(recycleVec), DW'(rVec));
    end
  endtask

  task automatic idle();
    instValid = 0; instFlush = 0; instIsVec = 0; instThread = 0; instTag = 0;
    instAddr = 0; instData = '0; instSize = 0; consumeMask = '0;
    missValid = 0; missThread = 0; missTag = 0; missAddr = 0; missData = '0;
    missSize = 0; missVec = 0; recycleConsume = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  task automatic push(logic v, logic f, logic [1:0] t, logic vec, logic [1:0] s, logic [DW-1:0] d);
    instValid = v; instFlush = f; instThread = t; instIsVec = vec; instSize = s;
    instData = d; instTag = 8'($urandom); instAddr = $urandom;
  endtask

  function automatic logic [DW-1:0] rndData();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    for (int i = 0; i < T; i++) mCnt[i] = 0;
    rV = 0; rThr = 0; rTag = 0; rAddr = 0; rData = '0; rSize = 0; rVec = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: state straight after reset
    for (int i = 0; i < T; i++) begin
      chk("R1", "queueEmpty", DW'(queueEmpty[i]), DW'(1));
      chk("R1", "queueFull", DW'(queueFull[i]), DW'(0));
      chk("R1", "headValid", DW'(headValid[i]), DW'(0));
    end
    chk("R1", "recycleValid", DW'(recycleValid), DW'(0));

    // R3: five pushes to thread 1, the fifth is refused
    for (int n = 0; n < 5; n++) begin
      push(1, 0, 2'd1, 0, 2'(n % 3), rndData());
      tick();
    end
    // R3: full queue refuses even while popping in the same cycle
    push(1, 0, 2'd1, 0, 2'd2, rndData()); consumeMask = 4'b0010;
    tick();
    idle();
    // R8: flush with instValid low
    push(0, 1, 2'd2, 0, 2'd0, rndData());
    tick();
    // R7: vector byte, half and word entries on thread 3
    for (int s = 0; s < 3; s++) begin
      push(1, 0, 2'd3, 1, 2'(s), rndData());
      tick();
    end
    idle();
    // R6: scalar byte and half on thread 0
    push(1, 0, 2'd0, 0, 2'd0, {4{32'hA1B2C3D4}}); tick();
    push(1, 0, 2'd0, 0, 2'd1, {4{32'h11223344}}); tick();
    idle();
    // R9/R10: miss for thread 1 blocks its head; consume bit 1 ignored
    missValid = 1; missThread = 2'd1; missTag = 8'h5A; missAddr = 32'hDEAD0000;
    missData = rndData(); missSize = 2'd2; missVec = 1;
    tick();
    idle(); consumeMask = 4'b0010;
    tick(); tick();
    // R11: consume and new capture in the same cycle
    idle(); recycleConsume = 1; missValid = 1; missThread = 2'd3; missTag = 8'hC3;
    missAddr = 32'h0000BEEF; missData = rndData();
    tick();
    idle(); recycleConsume = 1;
    tick();
    idle(); consumeMask = 4'b1111;
    repeat (6) tick();

    // Constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      push(($urandom % 2) == 1, ($urandom % 10) == 0, 2'($urandom), 1'($urandom),
           2'($urandom % 3), rndData());
      consumeMask = 4'($urandom);
      recycleConsume = ($urandom % 3) == 0;
      missValid = 0;
      if ((!rV || recycleConsume) && ($urandom % 5) == 0) begin
        missValid = 1; missThread = 2'($urandom); missTag = 8'($urandom);
        missAddr = $urandom; missData = rndData(); missSize = 2'($urandom);
        missVec = 1'($urandom);
      end
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule